// File: doc/BRIEF.md
# Page-Offset-Indexed Data Cache with Physical Tags

This block is a direct-mapped data cache of 1024 one-word lines (4 KB in total). It is looked up in the same cycle that address translation runs. The line index is taken from virtual address bits 11:2. Those bits lie inside the 12-bit page offset, so translation never changes them, and the array can be read before the physical page number arrives. The stored tag is the full 18-bit physical page number, and it is compared with the page number that the translation buffer returns in the same cycle. An access counts as a hit only when the line is valid, its tag matches, and translation reports a hit.

Reads that hit are accepted at once and answered one cycle later. A read that misses while translation hits raises busy and fetches the word from memory at the translated address. It fills the line and then completes as a hit. Every write is posted to a write buffer with its physical address. The same write also updates the line's data, tag and valid bit, whether the lookup hit or missed. When translation misses, the request is held off and a wait flag is raised, so that the normal translation path can resolve it.

Three handshakes follow valid/ready rules. The CPU request is one of them, and it must stay stable while `req_valid` is high and `req_ready` is low. The memory read request holds its valid and address until `mem_req_ready` is seen. The write buffer entry is offered while the write request is pending and is taken on `wb_valid && wb_ready`. That same edge completes the CPU write, so a full buffer back-pressures the CPU directly. The memory response and the read response are single-cycle pulses that have no ready signal.

Top module: `vipt_dcache`

## Requirements
- R1: Reset clears every line's valid bit, so the first read of any address after reset misses; busy, rsp_valid, mem_req_valid and wb_valid are low after reset.
- R2: The line index is virtual address bits 11:2 alone; two virtual addresses that differ only in bits 31:12 and translate to the same page number reach the same line.
- R3: The tag compare uses the full 18-bit translated page number; the same index under a different page number misses.
- R4: A read whose line is valid, whose tag matches and whose translation hits is accepted in the same cycle (req_ready high), and rsp_valid pulses with the line's word on the next cycle.
- R5: A read that misses with translation hit is not accepted. Busy rises after the edge, and mem_req_valid is driven with address {ppn, vaddr[11:2], 2'b00}, held stable until mem_req_ready. On mem_rsp_valid the line is filled and marked valid, and the held read then completes as a hit that returns the memory word.
- R6: While tr_hit is low, a request is not accepted and xlat_wait is high. No memory request and no write buffer entry is made, and the line store is left unchanged.
- R7: A write with translation hit offers a write buffer entry with wb_addr = {ppn, vaddr[11:2], 2'b00} and wb_data = write data. On acceptance it writes data, tag and valid into the line, on a hit and on a miss alike.
- R8: While wb_ready is low, a pending write is not accepted and the line is not modified.
- R9: Address bits 1:0 do not take part in the lookup; every access is a whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | CPU request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write data |
| tr_hit | input | 1 | Translation buffer hit for req_vaddr |
| tr_ppn | input | 18 | Translated physical page number |
| xlat_wait | output | 1 | Request held because translation missed |
| busy | output | 1 | Miss in progress, CPU stalled |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 30 | Physical byte address of the read |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| wb_valid | output | 1 | Write buffer entry valid |
| wb_ready | input | 1 | Write buffer can take an entry |
| wb_addr | output | 30 | Physical byte address of the write |
| wb_data | output | 32 | Write data for the buffer |

## Verification
The assertions assume the CPU keeps its address, data, direction and translation inputs steady while a request waits, and that memory returns data only after it has accepted a read request. The bench drives every request at the falling edge and holds it unchanged until it sees req_ready. It asserts mem_req_ready only while mem_req_valid is high, and it sends a single mem_rsp_valid pulse only after the request has been accepted. Expected hits and data come from a line model inside the bench that is updated from the requirements.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_LOOK  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 18,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];

  // R7
  line_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_idx != $past(wr_idx)) ||
              (rd_valid && rd_tag == $past(wr_tag) && rd_data == $past(wr_data)));
endmodule

// File: rtl/vipt_tag_cmp.sv
module vipt_tag_cmp #(
  parameter int TAG_W = 18
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] xlat_ppn,
  input  logic             xlat_hit,
  output logic             access_hit
);
  logic tag_eq;
  always_comb begin
    tag_eq     = (line_tag == xlat_ppn);
    access_hit = line_valid && tag_eq && xlat_hit;
  end
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic xlat_hit,
  input  logic access_hit,
  input  logic wb_ready,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic req_ready,
  output logic wb_valid,
  output logic mem_req_valid,
  output logic miss_start,
  output logic fill_en,
  output logic rd_hit,
  output logic busy,
  output logic xlat_wait
);
  ctl_state_e st_q, st_d;
  logic idle;

  always_comb begin
    idle          = (st_q == ST_LOOK);
    xlat_wait     = idle && req_valid && !xlat_hit;
    wb_valid      = idle && req_valid && xlat_hit && req_write;
    rd_hit        = idle && req_valid && !req_write && access_hit;
    miss_start    = idle && req_valid && xlat_hit && !req_write && !access_hit;
    req_ready     = rd_hit || (wb_valid && wb_ready);
    mem_req_valid = (st_q == ST_MREQ);
    fill_en       = (st_q == ST_MWAIT) && mem_rsp_valid;
    busy          = !idle;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LOOK:  if (miss_start)    st_d = ST_MREQ;
      ST_MREQ:  if (mem_req_ready) st_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid) st_d = ST_LOOK;
      default:                     st_d = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_LOOK;
    else        st_q <= st_d;
  end

  // R5
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid);
  // R5
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R6
  noxlat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !xlat_hit |-> !req_ready && !wb_valid && !mem_req_valid);
  // R8
  wb_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |-> !req_ready);
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
  parameter int VA_W       = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int PPN_W      = 18,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [VA_W-1:0]               req_vaddr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic                          tr_hit,
  input  logic [PPN_W-1:0]              tr_ppn,
  output logic                          xlat_wait,
  output logic                          busy,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [PPN_W+PAGE_OFF_W-1:0]   mem_req_addr,
  input  logic                          mem_rsp_valid,
  input  logic [DATA_W-1:0]             mem_rsp_data,
  output logic                          wb_valid,
  input  logic                          wb_ready,
  output logic [PPN_W+PAGE_OFF_W-1:0]   wb_addr,
  output logic [DATA_W-1:0]             wb_data
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int PA_W   = PPN_W + PAGE_OFF_W;

  logic [IDX_W-1:0]  look_idx;
  logic              line_valid;
  logic [PPN_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              access_hit;
  logic              miss_start, fill_en, rd_hit;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [PPN_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic [IDX_W-1:0]  miss_idx_q;
  logic [PPN_W-1:0]  miss_ppn_q;
  logic              unused_va_bits;

  assign look_idx       = req_vaddr[BYTE_W +: IDX_W];
  assign unused_va_bits = ^{req_vaddr[VA_W-1:BYTE_W+IDX_W], req_vaddr[BYTE_W-1:0]};

  vipt_line_store #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_idx), .rd_valid(line_valid), .rd_tag(line_tag), .rd_data(line_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  vipt_tag_cmp #(.TAG_W(PPN_W)) cmp_i (
    .line_valid(line_valid), .line_tag(line_tag),
    .xlat_ppn(tr_ppn), .xlat_hit(tr_hit), .access_hit(access_hit)
  );

  vipt_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .xlat_hit(tr_hit),
    .access_hit(access_hit), .wb_ready(wb_ready),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .req_ready(req_ready), .wb_valid(wb_valid), .mem_req_valid(mem_req_valid),
    .miss_start(miss_start), .fill_en(fill_en), .rd_hit(rd_hit),
    .busy(busy), .xlat_wait(xlat_wait)
  );

  always_comb begin
    wr_en   = fill_en || (wb_valid && wb_ready);
    wr_idx  = fill_en ? miss_idx_q   : look_idx;
    wr_tag  = fill_en ? miss_ppn_q   : tr_ppn;
    wr_data = fill_en ? mem_rsp_data : req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_idx_q <= '0;
      miss_ppn_q <= '0;
    end else if (miss_start) begin
      miss_idx_q <= look_idx;
      miss_ppn_q <= tr_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_hit;
      if (rd_hit) rsp_rdata <= line_data;
    end
  end

  assign mem_req_addr = {miss_ppn_q, miss_idx_q, {BYTE_W{1'b0}}};
  assign wb_addr      = {tr_ppn, look_idx, {BYTE_W{1'b0}}};
  assign wb_data      = req_wdata;

  // R5
  mreq_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));
  // R4
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));
  // R2
  wb_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_addr[PAGE_OFF_W-1:BYTE_W] == req_vaddr[PAGE_OFF_W-1:BYTE_W]);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !busy && !rsp_valid && !mem_req_valid);
endmodule

// File: tb/vipt_dcache_tb_top.sv
`timescale 1ns/1ps
module vipt_dcache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_vaddr, req_wdata;
  logic        tr_hit;
  logic [17:0] tr_ppn;
  logic        xlat_wait, busy, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_req_valid, mem_req_ready;
  logic [29:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        wb_valid, wb_ready;
  logic [29:0] wb_addr;
  logic [31:0] wb_data;

  int checks = 0;
  int fails  = 0;

  logic        m_vld [1024];
  logic [17:0] m_tag [1024];
  logic [31:0] m_dat [1024];

  always #2.5 clk = ~clk;

  vipt_dcache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata),
    .tr_hit(tr_hit), .tr_ppn(tr_ppn), .xlat_wait(xlat_wait), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] va;
    logic [17:0] ppn;
    logic [31:0] wd;
    logic        hit;
  } vec_t;

  localparam logic [17:0] PA_ = 18'h00123;
  localparam logic [17:0] PB_ = 18'h2F456;
  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    {1'b0, 32'h0000_0040, PA_, 32'h0, 1'b0},        // R1 cold miss
    {1'b0, 32'h0000_0040, PA_, 32'h0, 1'b1},        // R4 hit
    {1'b0, 32'hFFFF_F040, PA_, 32'h0, 1'b1},        // R2 upper bits differ
    {1'b0, 32'h0000_0043, PA_, 32'h0, 1'b1},        // R9 byte bits ignored
    {1'b0, 32'h0000_0040, PB_, 32'h0, 1'b0},        // R3 other page
    {1'b0, 32'h0000_0040, PA_, 32'h0, 1'b0},        // R3 back again
    {1'b1, 32'h0000_0040, PA_, 32'hDEAD_BEEF, 1'b1},// R7 write hit
    {1'b0, 32'h0000_0040, PA_, 32'h0, 1'b1},        // R7 read back
    {1'b1, 32'h0000_0FFC, PB_, 32'h1111_2222, 1'b0},// R7 write miss, last index
    {1'b0, 32'h0000_0FFC, PB_, 32'h0, 1'b1},        // R7 allocated
    {1'b0, 32'h0000_0000, PA_, 32'h0, 1'b0},        // R5 index 0 miss
    {1'b1, 32'h1234_5000, PB_, 32'h5A5A_0F0F, 1'b0},// R7 write over other tag
    {1'b0, 32'hABCD_E000, PB_, 32'h0, 1'b1}         // R2 R7 read back
  };

  function automatic logic [31:0] mem_word(input logic [29:0] pa);
    return ({2'b00, pa} * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [31:0] va, input logic [17:0] ppn);
    return m_vld[va[11:2]] && m_tag[va[11:2]] == ppn;
  endfunction

  task automatic do_read(input logic [31:0] va, input logic [17:0] ppn, input bit exp_hit,
                         input string rq, input int mdelay);
    logic [9:0]  ix = va[11:2];
    logic [29:0] pa = {ppn, ix, 2'b00};
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = va; tr_ppn = ppn; tr_hit = 1'b1;
    #1;
    chk(req_ready == exp_hit, rq, {31'd0, req_ready}, {31'd0, exp_hit});
    if (!req_ready) begin
      @(negedge clk); #1;
      chk(busy && mem_req_valid && mem_req_addr == pa, "R5", {2'b0, mem_req_addr}, {2'b0, pa});
      for (int k = 0; k < mdelay; k++) begin
        @(negedge clk); #1;
        chk(mem_req_valid && mem_req_addr == pa && !req_ready, "R5",
            {2'b0, mem_req_addr}, {2'b0, pa});
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(pa);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      m_vld[ix] = 1'b1; m_tag[ix] = ppn; m_dat[ix] = mem_word(pa);
      #1;
      chk(req_ready && !busy, "R5", {31'd0, req_ready}, 32'd1);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid && rsp_rdata == m_dat[ix], "R4", rsp_rdata, m_dat[ix]);
  endtask

  task automatic do_write(input logic [31:0] va, input logic [17:0] ppn, input logic [31:0] wd);
    logic [9:0]  ix = va[11:2];
    logic [29:0] pa = {ppn, ix, 2'b00};
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_vaddr = va; req_wdata = wd;
    tr_ppn = ppn; tr_hit = 1'b1;
    #1;
    chk(wb_valid && req_ready && wb_addr == pa, "R7", {2'b0, wb_addr}, {2'b0, pa});
    chk(wb_data == wd, "R7", wb_data, wd);
    @(posedge clk);
    m_vld[ix] = 1'b1; m_tag[ix] = ppn; m_dat[ix] = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 1024; i++) m_vld[i] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    req_valid = 0; req_write = 0; req_vaddr = '0; req_wdata = '0;
    tr_hit = 0; tr_ppn = '0; mem_req_ready = 0; mem_rsp_valid = 0;
    mem_rsp_data = '0; wb_ready = 1;
    for (int i = 0; i < 1024; i++) begin m_tag[i] = '0; m_dat[i] = '0; end
    apply_reset();
    #1;
    // R1 reset state
    chk(!busy && !rsp_valid && !mem_req_valid && !wb_valid, "R1",
        {28'd0, busy, rsp_valid, mem_req_valid, wb_valid}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      chk(model_hit(VEC[v].va, VEC[v].ppn) == VEC[v].hit, "R3 table",
          {31'd0, model_hit(VEC[v].va, VEC[v].ppn)}, {31'd0, VEC[v].hit});
      if (VEC[v].wr) do_write(VEC[v].va, VEC[v].ppn, VEC[v].wd);
      else           do_read(VEC[v].va, VEC[v].ppn, VEC[v].hit, "R4 R5 table", 0);
    end

    // R5 memory request held under back-pressure
    do_read(32'h0000_0800, PA_, 1'b0, "R5 hold", 2);

    // R6 translation miss: nothing accepted, nothing issued
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = 32'h0000_0040; tr_ppn = PB_; tr_hit = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(!req_ready && xlat_wait && !mem_req_valid && !wb_valid && !busy, "R6",
          {27'd0, req_ready, xlat_wait, mem_req_valid, wb_valid, busy}, 32'h8);
      @(negedge clk);
    end
    req_write = 1'b1; req_wdata = 32'h0BAD_0BAD;
    #1;
    chk(!req_ready && xlat_wait && !wb_valid, "R6", {31'd0, wb_valid}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    do_read(32'h0000_0040, PA_, model_hit(32'h0000_0040, PA_), "R6 line unchanged", 0);

    // R8 write buffer full
    wb_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_vaddr = 32'h0000_0040; tr_ppn = PA_;
    tr_hit = 1'b1; req_wdata = 32'hCAFE_F00D;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(wb_valid && !req_ready, "R8", {30'd0, wb_valid, req_ready}, 32'h2);
      @(negedge clk);
    end
    req_valid = 1'b0; req_write = 1'b0; wb_ready = 1'b1;
    do_read(32'h0000_0040, PA_, 1'b1, "R8 line unchanged", 0);
    do_write(32'h0000_0040, PA_, 32'hCAFE_F00D);
    do_read(32'h0000_0040, PA_, 1'b1, "R8 after accept", 0);

    // R1 reset in service clears all lines
    apply_reset();
    do_read(32'h0000_0040, PA_, 1'b0, "R1 after reset", 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule